// File: doc/BRIEF.md
# Shared-Unit Command Intake Dispatcher

This block is the front end that a scratchpad unit shares with a neighbouring hash unit on one command bus. Each cycle the bus may offer one command. The block compares the command's target field against its own unit identifier. Commands meant for any other unit, such as the hash unit, pass by untouched. Each command it takes is normalised and written as one entry (kind, reflector direction, address, length, tag) into a single in-order inlet FIFO. If the command will need write data, a pull request carrying its length and tag goes to the pull arbiter in the same cycle it is taken, not later when the command is serviced.

A service state machine pops one entry at a time from the FIFO. A plain read waits in READ for a push grant. A plain write waits in WRITE for pull data. Reflector reads and reflector writes are both folded onto the one REFLECT state, where a stored direction bit picks the handshake. Transitions: IDLE to READ, WRITE or REFLECT when the FIFO is non-empty (the entry is popped in that cycle). READ goes back to IDLE on push grant. WRITE goes back to IDLE on pull data valid. REFLECT goes back to IDLE on push grant if the reflector reads, or on pull data valid if it writes. Each state holds until its completion event.

Top module: `cmd_intake_top`

## Requirements
- R1: A command is accepted in a cycle exactly when `cmd_valid` is high, `cmd_ready` is high and `cmd_target` equals parameter `UNIT_ID` (default 1). At most one command is accepted per cycle, for all units together.
- R2: A command whose `cmd_target` differs from `UNIT_ID` is ignored. It raises no pull request, enters no FIFO entry and never completes in service.
- R3: The inlet FIFO holds `FIFO_DEPTH` (default 8) entries. `cmd_ready` is low while it is full, and no offered command is lost. With service stalled, exactly 9 commands are taken: one in service and eight queued.
- R4: Accepted commands complete in service in exactly the order they were accepted.
- R5: In the cycle a write (op 1) or reflector write (op 2) is accepted, `pull_req` is high, with `pull_len`/`pull_tag` equal to the command's length and tag. Reads (op 0) and reflector reads (op 3) raise no `pull_req`.
- R6: `svc_state` encodes IDLE=0, READ=1, WRITE=2, REFLECT=3. Op 0 is serviced in READ, op 1 in WRITE, and both op 2 and op 3 in REFLECT.
- R7: WRITE, and REFLECT for a reflector write, hold until `pull_dv` is high.
- R8: `push_req` is high, with the entry's tag and length, exactly while in READ or in REFLECT for a reflector read. The state holds until `push_gnt`.
- R9: During and right after reset the FIFO is empty (`cmd_ready` high), `pull_req`, `push_req` and `svc_done` are low, and `svc_state` is IDLE.
- R10: `svc_done` is high in the cycle the completion event is seen, with `svc_tag`/`svc_addr` of the serviced command. The next cycle the machine is IDLE or has popped the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered on the bus |
| cmd_ready | output | 1 | Inlet FIFO has room |
| cmd_target | input | TGT_W | Target unit identifier |
| cmd_op | input | 2 | 0 read, 1 write, 2 reflector write, 3 reflector read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_len | input | LEN_W | Transfer length |
| cmd_tag | input | TAG_W | Transaction identifier |
| pull_req | output | 1 | Pull-data request, same cycle as acceptance |
| pull_len | output | LEN_W | Length for the pull request |
| pull_tag | output | TAG_W | Identifier for the pull request |
| pull_dv | input | 1 | Pull data valid for the serviced command |
| push_req | output | 1 | Push request for the serviced command |
| push_len | output | LEN_W | Length for the push request |
| push_tag | output | TAG_W | Identifier for the push request |
| push_gnt | input | 1 | Push grant |
| svc_state | output | 2 | Service state code |
| svc_done | output | 1 | Serviced command completes this cycle |
| svc_tag | output | TAG_W | Tag of the command in service |
| svc_addr | output | ADDR_W | Address of the command in service |

## Verification
`pull_req` is combinational on the offered command, so the bench reads it one nanosecond after driving the command, before the accepting edge. An accepted command reaches the FIFO at that edge and is popped at the next one, so its service state shows one cycle after acceptance. The bench's responder raises `push_gnt` or `pull_dv` at a falling edge and reads `svc_done`, `svc_tag`, `svc_addr` and `svc_state` one nanosecond later, while the completion is still pending. The fill test stops the responder so that `cmd_ready` settles low after the ninth acceptance.

// File: rtl/cmd_intake_pkg.sv
package cmd_intake_pkg;

    typedef enum logic [1:0] {
        OP_READ     = 2'd0,
        OP_WRITE    = 2'd1,
        OP_RFL_WR   = 2'd2,
        OP_RFL_RD   = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        K_READ   = 2'd0,
        K_WRITE  = 2'd1,
        K_RFL    = 2'd2
    } svc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_READ    = 2'd1,
        ST_WRITE   = 2'd2,
        ST_REFLECT = 2'd3
    } svc_state_e;

endpackage

// File: rtl/cmd_intake_decode.sv
module cmd_intake_decode
    import cmd_intake_pkg::*;
#(
    parameter int unsigned TGT_W   = 2,
    parameter int unsigned UNIT_ID = 1,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned LEN_W   = 4,
    parameter int unsigned TAG_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [TGT_W-1:0]  cmd_target,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [TAG_W-1:0]  cmd_tag,
    input  logic              fifo_full,
    output logic              accept,
    output svc_kind_e         ent_kind,
    output logic              ent_rfl_rd,
    output logic              pull_req,
    output logic [LEN_W-1:0]  pull_len,
    output logic [TAG_W-1:0]  pull_tag
);
    localparam logic [TGT_W-1:0] MY_TGT = TGT_W'(UNIT_ID);

    logic hit;
    logic needs_pull;

    always_comb begin
        hit        = cmd_valid && (cmd_target == MY_TGT);
        accept     = hit && !fifo_full;
        needs_pull = 1'b0;
        ent_rfl_rd = 1'b0;
        ent_kind   = K_READ;
        unique case (cmd_op_e'(cmd_op))
            OP_READ:   ent_kind = K_READ;
            OP_WRITE:  begin ent_kind = K_WRITE; needs_pull = 1'b1; end
            OP_RFL_WR: begin ent_kind = K_RFL;   needs_pull = 1'b1; end
            OP_RFL_RD: begin ent_kind = K_RFL;   ent_rfl_rd = 1'b1; end
            default:   ent_kind = K_READ;
        endcase
        pull_req = accept && needs_pull;
        pull_len = cmd_len;
        pull_tag = cmd_tag;
    end

    // R2: a pull request only ever accompanies a command for this unit
    p_pull_own_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pull_req |-> (cmd_valid && cmd_target == MY_TGT))
        else $error("pull request for foreign target");

    // R3: nothing is taken while the FIFO is full
    p_no_take_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !pull_req)
        else $error("pull raised while full");

    logic unused_addr;
    assign unused_addr = ^cmd_addr;
endmodule

// File: rtl/cmd_intake_fifo.sv
module cmd_intake_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    assign full  = (count == CNT_MAX);
    assign empty = (count == '0);
    assign rdata = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= wdata;
                wr_ptr      <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3: never written while full
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full)
        else $error("fifo overflow");

    // R4: never read while empty
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty)
        else $error("fifo underflow");

    // R3: occupancy changes only through push or pop
    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(count))
        else $error("fifo count drifted");
endmodule

// File: rtl/cmd_intake_svc.sv
module cmd_intake_svc
    import cmd_intake_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned LEN_W  = 4,
    parameter int unsigned TAG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  svc_kind_e         in_kind,
    input  logic              in_rfl_rd,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              pop,
    input  logic              pull_dv,
    input  logic              push_gnt,
    output logic              push_req,
    output logic [LEN_W-1:0]  push_len,
    output logic [TAG_W-1:0]  push_tag,
    output svc_state_e        state,
    output logic              done,
    output logic [TAG_W-1:0]  cur_tag,
    output logic [ADDR_W-1:0] cur_addr
);
    svc_state_e       nxt;
    logic             cur_rfl_rd;
    logic [LEN_W-1:0] cur_len;

    // next-state process
    always_comb begin
        nxt  = state;
        pop  = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!fifo_empty) begin
                    pop = 1'b1;
                    unique case (in_kind)
                        K_READ:  nxt = ST_READ;
                        K_WRITE: nxt = ST_WRITE;
                        K_RFL:   nxt = ST_REFLECT;
                        default: nxt = ST_READ;
                    endcase
                end
            end
            ST_READ: begin
                done = push_gnt;
            end
            ST_WRITE: begin
                done = pull_dv;
            end
            ST_REFLECT: begin
                done = cur_rfl_rd ? push_gnt : pull_dv;
            end
            default: nxt = ST_IDLE;
        endcase
        if (done) nxt = ST_IDLE;
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_rfl_rd <= 1'b0;
            cur_len    <= '0;
            cur_tag    <= '0;
            cur_addr   <= '0;
        end else begin
            state <= nxt;
            if (pop) begin
                cur_rfl_rd <= in_rfl_rd;
                cur_len    <= in_len;
                cur_tag    <= in_tag;
                cur_addr   <= in_addr;
            end
        end
    end

    // output process
    always_comb begin
        push_req = (state == ST_READ) || (state == ST_REFLECT && cur_rfl_rd);
        push_len = cur_len;
        push_tag = cur_tag;
    end

    // R8: read waits for its grant
    p_read_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && !push_gnt) |=> (state == ST_READ))
        else $error("READ left without grant");

    // R7: write waits for its data
    p_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && !pull_dv) |=> (state == ST_WRITE))
        else $error("WRITE left without data");

    // R10: a completion returns to IDLE
    p_done_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state == ST_IDLE))
        else $error("no return to IDLE after completion");

    // R6: a new command is only taken from IDLE
    p_pop_from_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (state != ST_IDLE))
        else $error("pop without entering a service state");
endmodule

// File: rtl/cmd_intake_top.sv
module cmd_intake_top
    import cmd_intake_pkg::*;
#(
    parameter int unsigned TGT_W      = 2,
    parameter int unsigned UNIT_ID    = 1,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned LEN_W      = 4,
    parameter int unsigned TAG_W      = 5,
    parameter int unsigned FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [TGT_W-1:0]  cmd_target,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [TAG_W-1:0]  cmd_tag,
    output logic              pull_req,
    output logic [LEN_W-1:0]  pull_len,
    output logic [TAG_W-1:0]  pull_tag,
    input  logic              pull_dv,
    output logic              push_req,
    output logic [LEN_W-1:0]  push_len,
    output logic [TAG_W-1:0]  push_tag,
    input  logic              push_gnt,
    output logic [1:0]        svc_state,
    output logic              svc_done,
    output logic [TAG_W-1:0]  svc_tag,
    output logic [ADDR_W-1:0] svc_addr
);
    localparam int unsigned ENT_W = 2 + 1 + ADDR_W + LEN_W + TAG_W;

    logic              accept, fifo_full, fifo_empty, pop;
    svc_kind_e         d_kind, q_kind;
    logic              d_rfl_rd, q_rfl_rd;
    logic [ENT_W-1:0]  wdata, rdata;
    logic [ADDR_W-1:0] q_addr;
    logic [LEN_W-1:0]  q_len;
    logic [TAG_W-1:0]  q_tag;
    svc_state_e        st;

    cmd_intake_decode #(
        .TGT_W(TGT_W), .UNIT_ID(UNIT_ID), .ADDR_W(ADDR_W),
        .LEN_W(LEN_W), .TAG_W(TAG_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_target(cmd_target), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_tag(cmd_tag),
        .fifo_full(fifo_full), .accept(accept),
        .ent_kind(d_kind), .ent_rfl_rd(d_rfl_rd),
        .pull_req(pull_req), .pull_len(pull_len), .pull_tag(pull_tag)
    );

    assign wdata = {d_kind, d_rfl_rd, cmd_addr, cmd_len, cmd_tag};

    cmd_intake_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(accept), .wdata(wdata), .pop(pop), .rdata(rdata),
        .full(fifo_full), .empty(fifo_empty)
    );

    assign q_kind   = svc_kind_e'(rdata[ENT_W-1 -: 2]);
    assign q_rfl_rd = rdata[ENT_W-3];
    assign q_addr   = rdata[LEN_W+TAG_W +: ADDR_W];
    assign q_len    = rdata[TAG_W +: LEN_W];
    assign q_tag    = rdata[0 +: TAG_W];

    cmd_intake_svc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W)) u_svc (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty(fifo_empty), .in_kind(q_kind), .in_rfl_rd(q_rfl_rd),
        .in_addr(q_addr), .in_len(q_len), .in_tag(q_tag), .pop(pop),
        .pull_dv(pull_dv), .push_gnt(push_gnt),
        .push_req(push_req), .push_len(push_len), .push_tag(push_tag),
        .state(st), .done(svc_done), .cur_tag(svc_tag), .cur_addr(svc_addr)
    );

    assign cmd_ready = !fifo_full;
    assign svc_state = st;

    // R1: acceptance requires a valid command and free space
    p_accept_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (cmd_valid && cmd_ready))
        else $error("illegal acceptance");

    // R9: first cycle after reset is idle and quiet
    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> (svc_state == 2'd0 && !push_req && cmd_ready))
        else $error("not quiet after reset");
endmodule

// File: tb/tb_cmd_intake_top.sv
`timescale 1ns/1ps
module tb_cmd_intake_top;
    localparam int TGT_W = 2, ADDR_W = 12, LEN_W = 4, TAG_W = 5, MY_ID = 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_ready;
    logic [TGT_W-1:0]  cmd_target = '0;
    logic [1:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic [TAG_W-1:0]  cmd_tag = '0;
    logic pull_req, push_req, svc_done;
    logic [LEN_W-1:0] pull_len, push_len;
    logic [TAG_W-1:0] pull_tag, push_tag, svc_tag;
    logic pull_dv = 1'b0, push_gnt = 1'b0;
    logic [1:0] svc_state;
    logic [ADDR_W-1:0] svc_addr;

    always #2.5 clk = ~clk;

    cmd_intake_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_target(cmd_target), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_tag(cmd_tag),
        .pull_req(pull_req), .pull_len(pull_len), .pull_tag(pull_tag), .pull_dv(pull_dv),
        .push_req(push_req), .push_len(push_len), .push_tag(push_tag), .push_gnt(push_gnt),
        .svc_state(svc_state), .svc_done(svc_done), .svc_tag(svc_tag), .svc_addr(svc_addr)
    );

    int n_chk = 0, n_bad = 0;
    bit resp_en = 1'b0;
    logic [TAG_W-1:0]  exp_tag  [256];
    logic [ADDR_W-1:0] exp_addr [256];
    logic [1:0]        exp_st   [256];
    logic [LEN_W-1:0]  exp_len  [256];
    int wr_i = 0, rd_i = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] state_of(input logic [1:0] op);
        return (op == 2'd0) ? 2'd1 : (op == 2'd1) ? 2'd2 : 2'd3;
    endfunction

    // responder and completion monitor
    initial begin
        forever begin
            @(negedge clk);
            push_gnt = resp_en && push_req;
            pull_dv  = resp_en && (svc_state == 2'd2 || (svc_state == 2'd3 && !push_req));
            #1;
            if (push_req && svc_state != 2'd1 && svc_state != 2'd3)
                chk("R8 push_req outside READ/REFLECT", svc_state, 1);
            if (svc_done) begin
                if (rd_i >= wr_i) chk("R2 unexpected completion", svc_tag, -1);
                else begin
                    chk("R4 order tag", svc_tag, exp_tag[rd_i % 256]);
                    chk("R10 done addr", svc_addr, exp_addr[rd_i % 256]);
                    chk("R6 service state", svc_state, exp_st[rd_i % 256]);
                    if (push_req) chk("R8 push_len", push_len, exp_len[rd_i % 256]);
                    rd_i++;
                end
            end
        end
    end

    // offer one command; returns 1 if accepted within the wait limit
    task automatic send(input logic [1:0] tgt, input logic [1:0] op,
                        input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l,
                        input logic [TAG_W-1:0] t, output bit took);
        bit mine;
        int w;
        mine = (tgt == MY_ID);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_target = tgt; cmd_op = op;
        cmd_addr = a; cmd_len = l; cmd_tag = t;
        w = 0;
        while (mine && !cmd_ready && w < 12) begin @(negedge clk); w++; end
        took = 1'b0;
        if (!mine || cmd_ready) begin
            #1;
            chk("R5 pull_req", pull_req, (mine && (op == 2'd1 || op == 2'd2)) ? 1 : 0);
            if (pull_req) begin
                chk("R5 pull_len", pull_len, l);
                chk("R5 pull_tag", pull_tag, t);
            end
            if (mine) begin
                exp_tag[wr_i % 256] = t; exp_addr[wr_i % 256] = a;
                exp_st[wr_i % 256] = state_of(op); exp_len[wr_i % 256] = l;
                wr_i++;
                took = 1'b1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit took;
        int cnt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 ready in reset", cmd_ready, 1);
        chk("R9 state in reset", svc_state, 0);
        chk("R9 push_req in reset", push_req, 0);
        chk("R9 pull_req in reset", pull_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 done after reset", svc_done, 0);
        resp_en = 1'b1;

        // R1 R2 R5 R6: sweep every target and opcode
        for (int tg = 0; tg < 4; tg++)
            for (int op = 0; op < 4; op++)
                send(2'(tg), 2'(op), 12'(tg * 64 + op * 7 + 3), 4'(op + tg + 1),
                     5'(tg * 4 + op), took);
        repeat (20) @(negedge clk);
        chk("R2 only own target completes", rd_i, 4);

        // R7: write stalls until pull data
        resp_en = 1'b0;
        send(2'(MY_ID), 2'd1, 12'h123, 4'd5, 5'd20, took);
        repeat (5) @(negedge clk);
        #1 chk("R7 WRITE holds", svc_state, 2);
        // R8: reflector read queued behind, push held until grant
        send(2'(MY_ID), 2'd3, 12'h321, 4'd9, 5'd21, took);
        resp_en = 1'b1;
        repeat (6) @(negedge clk);
        chk("R7 R8 both completed", rd_i, 6);

        // R3: fill with service stalled
        resp_en = 1'b0;
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            send(2'(MY_ID), 2'(i % 4), 12'(i * 3 + 100), 4'(i), 5'(i + 1), took);
            if (took) cnt++;
        end
        chk("R3 accepted while stalled", cnt, 9);
        chk("R3 ready low when full", cmd_ready, 0);
        resp_en = 1'b1;
        send(2'(MY_ID), 2'd0, 12'h0AA, 4'd2, 5'd30, took);
        chk("R3 accepted after drain starts", took, 1);
        // R4: hash-unit command interleaved must not appear
        send(2'(2), 2'd1, 12'h0BB, 4'd1, 5'd31, took);
        send(2'(MY_ID), 2'd2, 12'h0CC, 4'd3, 5'd29, took);
        repeat (60) @(negedge clk);
        chk("R4 all accepted completed", rd_i, wr_i);
        chk("R10 back to IDLE", svc_state, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule